// File: doc/BRIEF.md
# Dual-Channel Interrupt Status Mirror

This block keeps the interrupt status of a two-channel disk controller. Each channel has one interrupt flag, and that flag is held twice: once in a per-channel status byte and once in a shared mode byte. The block keeps the two copies equal whatever path changes them. It also drives a single level-sensitive interrupt line, which is the OR of the channels whose flag is set and whose block bit is clear.

Three sources change the state. A per-channel event input sets or clears that channel's flag according to its level. A configuration write port writes one to four consecutive bytes from a byte address. There the flags are write-one-to-clear, and every other bit of the three registers is read-only. A write path from the DMA register window replaces only the two block bits of the mode byte. Configuration readback is combinational from the held state.

Top module: `dual_irq_mirror`

## Requirements
- R1: After reset every flag and block bit is zero: the interrupt line is low and the bytes at 0x50, 0x57 and 0x71 read 0x00.
- R2: A channel event sets that channel's flag when its level is 1 and clears it when its level is 0. Both copies follow: channel 0 appears at 0x50 bit 2 and 0x71 bit 2, channel 1 at 0x57 bit 4 and 0x71 bit 3.
- R3: The interrupt line is registered. It is high when some channel has its flag set and its block bit clear (channel 0 block at 0x71 bit 4, channel 1 block at 0x71 bit 5). It changes at the same clock edge as the state that causes it.
- R4: A configuration byte written to 0x50 or 0x57 with a one in that register's flag bit clears the flag, and the copy in 0x71 follows. A zero in the flag bit leaves the flag as it was.
- R5: A configuration byte written to 0x71 with a one in bit 2 or bit 3 clears that channel's flag, and the copy in 0x50 or 0x57 follows.
- R6: Through the configuration port, no bit of 0x50, 0x57 or 0x71 other than the flags can be changed. This includes the block bits, and no configuration write can set a flag.
- R7: A DMA-window mode write loads bits 5:4 of its byte into the block bits and leaves both flags unchanged. The interrupt line is recomputed from the new block bits.
- R8: A configuration write carries a start address and a length of 1 to 4. Byte i of the data (bits 8i+7:8i) goes to address start+i, and each covered byte takes effect as if it had been written alone.
- R9: When sources coincide in one cycle, the configuration clears apply first, then the DMA-window write, then the channel events. An event therefore overrides a clear of the same flag.
- R10: Configuration writes to any other address leave all state and the interrupt line unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_valid | input | 2 | Per-channel event strobe |
| evt_level | input | 2 | Per-channel event level (1 set, 0 clear) |
| cfg_wr_en | input | 1 | Configuration write strobe |
| cfg_wr_addr | input | 8 | Start byte address of the write |
| cfg_wr_len | input | 3 | Number of bytes written (1 to 4) |
| cfg_wr_data | input | 32 | Write data, byte i for address start+i |
| dma_mode_wr_en | input | 1 | DMA-window mode byte write strobe |
| dma_mode_wr_data | input | 8 | DMA-window mode byte write data |
| cfg_rd_addr | input | 8 | Readback byte address |
| cfg_rd_data | output | 8 | Readback byte (combinational) |
| irq_out | output | 1 | Combined interrupt line (registered) |

## Verification
The hardest situation to reach is a cycle in which a configuration clear, a DMA-window block update and a channel event all land together. Only there does the fixed ordering show, and a wrong order leaves a flag one way in one copy and the other way in the other copy. The stimulus table therefore has vectors that combine two or three sources in a single cycle. It also has multi-byte writes whose flag-carrying byte is not the first one, so an error in the byte lane or the address offset shows up as a flag that was not cleared. Each vector is checked at all three readback bytes, so any mismatch between the copies becomes visible.

// File: rtl/irqmir_pkg.sv
package irqmir_pkg;

    localparam int NCH        = 2;
    localparam int ADDR_W     = 8;
    localparam int CFG_BYTES  = 4;
    localparam int LEN_W      = $clog2(CFG_BYTES + 1);
    localparam int DATA_W     = 8 * CFG_BYTES;

    localparam logic [ADDR_W-1:0] OFS_STAT0 = 8'h50;
    localparam logic [ADDR_W-1:0] OFS_STAT1 = 8'h57;
    localparam logic [ADDR_W-1:0] OFS_MODE  = 8'h71;

    localparam int STAT0_BIT  = 2;
    localparam int STAT1_BIT  = 4;
    localparam int MFLAG_LSB  = 2;
    localparam int MBLK_LSB   = 4;

    typedef struct packed {
        logic [NCH-1:0] stat_flag;
        logic [NCH-1:0] mode_flag;
        logic [NCH-1:0] blk;
    } irq_state_t;

    function automatic logic [ADDR_W-1:0] stat_ofs(input int ch);
        return (ch == 0) ? OFS_STAT0 : OFS_STAT1;
    endfunction

    function automatic logic [7:0] stat_mask(input int ch);
        return (ch == 0) ? (8'h01 << STAT0_BIT) : (8'h01 << STAT1_BIT);
    endfunction

    function automatic logic [7:0] mflag_mask(input int ch);
        return 8'h01 << (MFLAG_LSB + ch);
    endfunction

    function automatic logic [7:0] mode_byte(input irq_state_t s);
        logic [7:0] b;
        b = '0;
        for (int c = 0; c < NCH; c++) begin
            b[MFLAG_LSB + c] = s.mode_flag[c];
            b[MBLK_LSB + c]  = s.blk[c];
        end
        return b;
    endfunction

endpackage

// File: rtl/irqmir_cfg_decode.sv
module irqmir_cfg_decode
    import irqmir_pkg::*;
#(
    parameter int NBYTES = CFG_BYTES,
    localparam int LW    = $clog2(NBYTES + 1)
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  wr_en,
    input  logic [ADDR_W-1:0]     wr_addr,
    input  logic [LW-1:0]         wr_len,
    input  logic [8*NBYTES-1:0]   wr_data,
    output logic [NCH-1:0]        clr_stat,
    output logic [NCH-1:0]        clr_mode,
    output logic [NBYTES-1:0]     hit_stat,
    output logic [NBYTES-1:0]     hit_mode
);

    logic [NCH-1:0] clr_stat_b [NBYTES];
    logic [NCH-1:0] clr_mode_b [NBYTES];

    for (genvar b = 0; b < NBYTES; b++) begin : g_lane
        logic [ADDR_W-1:0] lane_addr;
        logic              lane_act;
        logic [7:0]        lane_data;

        assign lane_addr = wr_addr + ADDR_W'(b);
        assign lane_act  = wr_en && (LW'(b) < wr_len);
        assign lane_data = wr_data[8*b +: 8];

        assign hit_stat[b] = lane_act &&
                             ((lane_addr == OFS_STAT0) || (lane_addr == OFS_STAT1));
        assign hit_mode[b] = lane_act && (lane_addr == OFS_MODE);

        for (genvar c = 0; c < NCH; c++) begin : g_ch
            assign clr_stat_b[b][c] = lane_act && (lane_addr == stat_ofs(c)) &&
                                      (|(lane_data & stat_mask(c)));
            assign clr_mode_b[b][c] = hit_mode[b] && (|(lane_data & mflag_mask(c)));
        end
    end

    always_comb begin
        clr_stat = '0;
        clr_mode = '0;
        for (int b = 0; b < NBYTES; b++) begin
            clr_stat |= clr_stat_b[b];
            clr_mode |= clr_mode_b[b];
        end
    end

    // R8: the write length must stay within the port width
    assert_len_legal_R8: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> (wr_len >= LW'(1)) && (wr_len <= LW'(NBYTES)));

    // R8/R10: a lane outside the written range never produces a hit
    assert_no_hit_idle_R10: assert property (@(posedge clk) disable iff (rst)
        !wr_en |-> (hit_stat == '0) && (hit_mode == '0) &&
                   (clr_stat == '0) && (clr_mode == '0));

endmodule

// File: rtl/irqmir_state.sv
module irqmir_state
    import irqmir_pkg::*;
#(
    parameter int NBYTES = CFG_BYTES
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NCH-1:0]    evt_valid,
    input  logic [NCH-1:0]    evt_level,
    input  logic [NCH-1:0]    clr_stat,
    input  logic [NCH-1:0]    clr_mode,
    input  logic [NBYTES-1:0] hit_stat,
    input  logic [NBYTES-1:0] hit_mode,
    input  logic              cfg_wr_en,
    input  logic              dma_wr_en,
    input  logic [7:0]        dma_wr_data,
    output irq_state_t        state_q,
    output logic              irq_q
);

    irq_state_t stage [NBYTES+1];
    irq_state_t after_dma;
    irq_state_t state_d;
    logic       irq_d;

    // Step 1: all write-one-to-clear effects of the configuration write
    always_comb begin
        stage[0] = state_q;
        stage[0].stat_flag = state_q.stat_flag & ~clr_stat;
        stage[0].mode_flag = state_q.mode_flag & ~clr_mode;
    end

    // Step 2: per covered byte, ascending address, copy in the right direction
    for (genvar b = 0; b < NBYTES; b++) begin : g_mirror
        always_comb begin
            stage[b+1] = stage[b];
            if (hit_stat[b]) begin
                stage[b+1].mode_flag = stage[b].stat_flag;
            end else if (hit_mode[b]) begin
                stage[b+1].stat_flag = stage[b].mode_flag;
            end
        end
    end

    // Step 3: DMA-window write replaces only the block field of the mode byte
    always_comb begin
        logic [7:0] cur_mode;
        logic [7:0] new_mode;
        after_dma = stage[NBYTES];
        cur_mode  = mode_byte(stage[NBYTES]);
        new_mode  = (cur_mode & ~8'h30) | (dma_wr_data & 8'h30);
        if (dma_wr_en) begin
            after_dma.blk = new_mode[MBLK_LSB +: NCH];
        end
    end

    // Step 4: channel events have the last word and update both copies
    always_comb begin
        state_d = after_dma;
        for (int c = 0; c < NCH; c++) begin
            if (evt_valid[c]) begin
                state_d.mode_flag[c] = evt_level[c];
                state_d.stat_flag[c] = evt_level[c];
            end
        end
        irq_d = |(state_d.mode_flag & ~state_d.blk);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= '0;
            irq_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            irq_q   <= irq_d;
        end
    end

    // R1: reset clears everything and drops the line
    assert_reset_clear_R1: assert property (@(posedge clk)
        rst |=> (state_q == '0) && !irq_q);

    // R2: both copies of every flag stay equal
    assert_copies_equal_R2: assert property (@(posedge clk) disable iff (rst)
        state_q.stat_flag == state_q.mode_flag);

    for (genvar c = 0; c < NCH; c++) begin : g_evt_chk
        // R2/R9: an event decides the flag whatever else happens in the cycle
        assert_evt_wins_R9: assert property (@(posedge clk) disable iff (rst)
            evt_valid[c] |=> state_q.mode_flag[c] == $past(evt_level[c]));
    end

    // R3: a fully blocked controller never raises the line
    assert_blocked_quiet_R3: assert property (@(posedge clk) disable iff (rst)
        (&state_q.blk) |-> !irq_q);

    // R3: without any source active the line holds its level
    assert_line_holds_R3: assert property (@(posedge clk) disable iff (rst)
        (!cfg_wr_en && !dma_wr_en && (evt_valid == '0)) |=> $stable(irq_q));

    // R7: a lone DMA-window write never touches the flags
    assert_dma_keeps_flags_R7: assert property (@(posedge clk) disable iff (rst)
        (dma_wr_en && !cfg_wr_en && (evt_valid == '0)) |=>
            $stable(state_q.mode_flag) && $stable(state_q.stat_flag));

    // R6: configuration writes alone never change block bits nor set a flag
    assert_cfg_no_set_R6: assert property (@(posedge clk) disable iff (rst)
        (cfg_wr_en && !dma_wr_en && (evt_valid == '0)) |=>
            $stable(state_q.blk) &&
            ((state_q.mode_flag & ~$past(state_q.mode_flag)) == '0));

endmodule

// File: rtl/irqmir_readback.sv
module irqmir_readback
    import irqmir_pkg::*;
(
    input  irq_state_t        state,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [7:0]        rd_data
);

    logic [7:0] stat_byte [NCH];

    for (genvar c = 0; c < NCH; c++) begin : g_stat
        assign stat_byte[c] = state.stat_flag[c] ? stat_mask(c) : 8'h00;
    end

    always_comb begin
        rd_data = 8'h00;
        for (int c = 0; c < NCH; c++) begin
            if (rd_addr == stat_ofs(c)) begin
                rd_data = stat_byte[c];
            end
        end
        if (rd_addr == OFS_MODE) begin
            rd_data = mode_byte(state);
        end
    end

endmodule

// File: rtl/dual_irq_mirror.sv
module dual_irq_mirror
    import irqmir_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic [NCH-1:0]        evt_valid,
    input  logic [NCH-1:0]        evt_level,
    input  logic                  cfg_wr_en,
    input  logic [ADDR_W-1:0]     cfg_wr_addr,
    input  logic [LEN_W-1:0]      cfg_wr_len,
    input  logic [DATA_W-1:0]     cfg_wr_data,
    input  logic                  dma_mode_wr_en,
    input  logic [7:0]            dma_mode_wr_data,
    input  logic [ADDR_W-1:0]     cfg_rd_addr,
    output logic [7:0]            cfg_rd_data,
    output logic                  irq_out
);

    logic [NCH-1:0]       clr_stat;
    logic [NCH-1:0]       clr_mode;
    logic [CFG_BYTES-1:0] hit_stat;
    logic [CFG_BYTES-1:0] hit_mode;
    irq_state_t           state_q;

    irqmir_cfg_decode #(.NBYTES(CFG_BYTES)) u_dec (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (cfg_wr_en),
        .wr_addr  (cfg_wr_addr),
        .wr_len   (cfg_wr_len),
        .wr_data  (cfg_wr_data),
        .clr_stat (clr_stat),
        .clr_mode (clr_mode),
        .hit_stat (hit_stat),
        .hit_mode (hit_mode)
    );

    irqmir_state #(.NBYTES(CFG_BYTES)) u_state (
        .clk         (clk),
        .rst         (rst),
        .evt_valid   (evt_valid),
        .evt_level   (evt_level),
        .clr_stat    (clr_stat),
        .clr_mode    (clr_mode),
        .hit_stat    (hit_stat),
        .hit_mode    (hit_mode),
        .cfg_wr_en   (cfg_wr_en),
        .dma_wr_en   (dma_mode_wr_en),
        .dma_wr_data (dma_mode_wr_data),
        .state_q     (state_q),
        .irq_q       (irq_out)
    );

    irqmir_readback u_rb (
        .state   (state_q),
        .rd_addr (cfg_rd_addr),
        .rd_data (cfg_rd_data)
    );

    // R10: a write outside the three registers leaves the line alone
    assert_foreign_write_R10: assert property (@(posedge clk) disable iff (rst)
        (cfg_wr_en && !dma_mode_wr_en && (evt_valid == '0) &&
         (hit_stat == '0) && (hit_mode == '0)) |=> $stable(irq_out));

endmodule

// File: tb/sim_dual_irq_mirror.sv
module sim_dual_irq_mirror;

    typedef struct packed {
        logic [1:0]  ev;
        logic [1:0]  el;
        logic        cw;
        logic [7:0]  ca;
        logic [2:0]  cl;
        logic [31:0] cd;
        logic        dw;
        logic [7:0]  dd;
        logic        x_irq;
        logic [7:0]  x50;
        logic [7:0]  x57;
        logic [7:0]  x71;
    } vec_t;

    localparam int NV = 16;

    // fields: ev el cw addr len data dw ddata | irq 0x50 0x57 0x71
    localparam vec_t TBL [NV] = '{
        '{2'b01, 2'b01, 1'b0, 8'h00, 3'd0, 32'h0, 1'b0, 8'h00, 1'b1, 8'h04, 8'h00, 8'h04}, // R2 ch0 set
        '{2'b10, 2'b10, 1'b0, 8'h00, 3'd0, 32'h0, 1'b0, 8'h00, 1'b1, 8'h04, 8'h10, 8'h0C}, // R2 ch1 set
        '{2'b00, 2'b00, 1'b0, 8'h00, 3'd0, 32'h0, 1'b1, 8'h30, 1'b0, 8'h04, 8'h10, 8'h3C}, // R3 both blocked
        '{2'b00, 2'b00, 1'b0, 8'h00, 3'd0, 32'h0, 1'b1, 8'hFF, 1'b0, 8'h04, 8'h10, 8'h3C}, // R7 only bits 5:4
        '{2'b00, 2'b00, 1'b0, 8'h00, 3'd0, 32'h0, 1'b1, 8'h10, 1'b1, 8'h04, 8'h10, 8'h1C}, // R7 unblock ch1
        '{2'b00, 2'b00, 1'b1, 8'h50, 3'd1, 32'h0, 1'b0, 8'h00, 1'b1, 8'h04, 8'h10, 8'h1C}, // R4 zero no effect
        '{2'b00, 2'b00, 1'b1, 8'h71, 3'd1, 32'h30, 1'b0, 8'h00, 1'b1, 8'h04, 8'h10, 8'h1C}, // R6 block ro
        '{2'b00, 2'b00, 1'b1, 8'h54, 3'd4, 32'h10000000, 1'b0, 8'h00, 1'b0, 8'h04, 8'h00, 8'h14}, // R8 lane 3
        '{2'b00, 2'b00, 1'b1, 8'h70, 3'd2, 32'h0400, 1'b0, 8'h00, 1'b0, 8'h00, 8'h00, 8'h10}, // R5 via lane 1
        '{2'b11, 2'b11, 1'b0, 8'h00, 3'd0, 32'h0, 1'b0, 8'h00, 1'b1, 8'h04, 8'h10, 8'h1C}, // R2 both set
        '{2'b00, 2'b00, 1'b1, 8'h50, 3'd1, 32'hFF, 1'b0, 8'h00, 1'b1, 8'h00, 8'h10, 8'h18}, // R4 clear ch0
        '{2'b00, 2'b00, 1'b1, 8'h60, 3'd4, 32'hFFFFFFFF, 1'b0, 8'h00, 1'b1, 8'h00, 8'h10, 8'h18}, // R10
        '{2'b10, 2'b10, 1'b1, 8'h57, 3'd1, 32'h10, 1'b0, 8'h00, 1'b1, 8'h00, 8'h10, 8'h18}, // R9 event wins
        '{2'b01, 2'b01, 1'b1, 8'h71, 3'd1, 32'h08, 1'b1, 8'h30, 1'b0, 8'h04, 8'h00, 8'h34}, // R9 three sources
        '{2'b01, 2'b00, 1'b0, 8'h00, 3'd0, 32'h0, 1'b0, 8'h00, 1'b0, 8'h00, 8'h00, 8'h30}, // R2 ch0 clear
        '{2'b10, 2'b10, 1'b0, 8'h00, 3'd0, 32'h0, 1'b1, 8'h00, 1'b1, 8'h00, 8'h10, 8'h08}  // R3 line high
    };

    localparam string REQ [NV] = '{
        "R2", "R2", "R3", "R7", "R7", "R4", "R6", "R8",
        "R5", "R2", "R4", "R10", "R9", "R9", "R2", "R3"
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  evt_valid = '0;
    logic [1:0]  evt_level = '0;
    logic        cfg_wr_en = 1'b0;
    logic [7:0]  cfg_wr_addr = '0;
    logic [2:0]  cfg_wr_len = '0;
    logic [31:0] cfg_wr_data = '0;
    logic        dma_mode_wr_en = 1'b0;
    logic [7:0]  dma_mode_wr_data = '0;
    logic [7:0]  cfg_rd_addr = '0;
    logic [7:0]  cfg_rd_data;
    logic        irq_out;

    int n_chk  = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    dual_irq_mirror u0 (
        .clk              (clk),
        .rst              (rst),
        .evt_valid        (evt_valid),
        .evt_level        (evt_level),
        .cfg_wr_en        (cfg_wr_en),
        .cfg_wr_addr      (cfg_wr_addr),
        .cfg_wr_len       (cfg_wr_len),
        .cfg_wr_data      (cfg_wr_data),
        .dma_mode_wr_en   (dma_mode_wr_en),
        .dma_mode_wr_data (dma_mode_wr_data),
        .cfg_rd_addr      (cfg_rd_addr),
        .cfg_rd_data      (cfg_rd_data),
        .irq_out          (irq_out)
    );

    task automatic check(input string req, input string what,
                         input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%02h expected 0x%02h", req, what, act, exp);
        end
    endtask

    task automatic read_regs(output logic [7:0] r50, output logic [7:0] r57,
                             output logic [7:0] r71);
        cfg_rd_addr = 8'h50; #1 r50 = cfg_rd_data;
        cfg_rd_addr = 8'h57; #1 r57 = cfg_rd_data;
        cfg_rd_addr = 8'h71; #1 r71 = cfg_rd_data;
    endtask

    task automatic idle_inputs();
        evt_valid = '0; evt_level = '0;
        cfg_wr_en = 1'b0; cfg_wr_addr = '0; cfg_wr_len = '0; cfg_wr_data = '0;
        dma_mode_wr_en = 1'b0; dma_mode_wr_data = '0;
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        #2_000_000;
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        finish_run();
    end

    initial begin
        logic [7:0] r50, r57, r71;

        // R1: state after reset
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;
        read_regs(r50, r57, r71);
        check("R1", "irq after reset", {7'd0, irq_out}, 8'h00);
        check("R1", "0x50 after reset", r50, 8'h00);
        check("R1", "0x57 after reset", r57, 8'h00);
        check("R1", "0x71 after reset", r71, 8'h00);

        // table walk
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            evt_valid        = TBL[i].ev;
            evt_level        = TBL[i].el;
            cfg_wr_en        = TBL[i].cw;
            cfg_wr_addr      = TBL[i].ca;
            cfg_wr_len       = TBL[i].cl;
            cfg_wr_data      = TBL[i].cd;
            dma_mode_wr_en   = TBL[i].dw;
            dma_mode_wr_data = TBL[i].dd;
            @(posedge clk);
            #1 idle_inputs();
            read_regs(r50, r57, r71);
            check(REQ[i], $sformatf("vec %0d irq", i), {7'd0, irq_out}, {7'd0, TBL[i].x_irq});
            check(REQ[i], $sformatf("vec %0d 0x50", i), r50, TBL[i].x50);
            check(REQ[i], $sformatf("vec %0d 0x57", i), r57, TBL[i].x57);
            check(REQ[i], $sformatf("vec %0d 0x71", i), r71, TBL[i].x71);
        end

        // R1: reset in the middle of activity (line is high here)
        @(negedge clk) rst = 1'b1;
        @(posedge clk);
        #1 rst = 1'b0;
        read_regs(r50, r57, r71);
        check("R1", "irq after mid reset", {7'd0, irq_out}, 8'h00);
        check("R1", "0x71 after mid reset", r71, 8'h00);
        check("R1", "0x57 after mid reset", r57, 8'h00);

        // R3: the line rises exactly at the edge that stores the flag
        @(negedge clk);
        evt_valid = 2'b01; evt_level = 2'b01;
        #2 check("R3", "irq before edge", {7'd0, irq_out}, 8'h00);
        @(posedge clk);
        #1 idle_inputs();
        check("R3", "irq after edge", {7'd0, irq_out}, 8'h01);

        // R8: length 1 at 0x56 does not reach 0x57; length 2 does
        @(negedge clk);
        evt_valid = 2'b10; evt_level = 2'b10;
        @(posedge clk);
        #1 idle_inputs();
        @(negedge clk);
        cfg_wr_en = 1'b1; cfg_wr_addr = 8'h56; cfg_wr_len = 3'd1; cfg_wr_data = 32'h1010;
        @(posedge clk);
        #1 idle_inputs();
        read_regs(r50, r57, r71);
        check("R8", "0x57 after short write", r57, 8'h10);
        @(negedge clk);
        cfg_wr_en = 1'b1; cfg_wr_addr = 8'h56; cfg_wr_len = 3'd2; cfg_wr_data = 32'h1000;
        @(posedge clk);
        #1 idle_inputs();
        read_regs(r50, r57, r71);
        check("R8", "0x57 after two-byte write", r57, 8'h00);
        check("R8", "0x71 after two-byte write", r71, 8'h04);

        // R10: readback of an unrelated address is zero
        cfg_rd_addr = 8'h51; #1;
        check("R10", "0x51 readback", cfg_rd_data, 8'h00);

        finish_run();
    end

endmodule